// File: doc/BRIEF.md
# 100BASE-X Stream Delimiter Carrier Detector

This block sits on a 100BASE-X receive path after code-group alignment. It takes aligned 5-bit code groups, each marked by a one-cycle strobe, and produces carrier sense, receive-data-valid and receive-error. It also produces a gated copy of the code group whose enable stays low until real payload arrives. A frame opens on the start pair /J/K/ and closes on the end pair /T/R/. If two idle code groups arrive inside a frame with no end pair, the frame is cut short and an error flag is raised. That flag stays up through the gap until the next frame begins.

Every output is a register that updates only on a clock edge where the strobe is high. Between strobes the outputs hold, so the block can run on a clock faster than the symbol rate. Payload decoding downstream reads `dataOut` only while `dataEn` is high; at all other times `dataOut` is zero.

Top module: `delim_carrier_top`

## Requirements
- R1: After a strobed /K/ (10001) that directly follows a strobed /J/ (11000), `crs` and `rxDv` are 1 and `rxEr` is 0.
- R2: A /J/ followed by any code group other than /K/ asserts nothing; a further /J/ restarts the pair, so /J/J/K/ opens a frame.
- R3: Inside a frame, /T/ (01101) directly followed by /R/ (00111) returns `crs` and `rxDv` to 0 after the /R/ strobe, and `rxEr` stays 0.
- R4: Inside a frame, two consecutive idle code groups (11111) drop `crs` and `rxDv` and set `rxEr` after the second idle; a single idle followed by data does not end the frame.
- R5: After an idle-terminated frame, `rxEr` stays 1 through following idles and a /J/, and clears only on the /K/ that opens the next frame.
- R6: `rxDv` is never 1 while `crs` is 0, and `rxEr` is never 1 while `crs` is 1.
- R7: `dataEn` is 1 and `dataOut` equals the strobed code group only for a payload code group inside a frame; after any delimiter, idle or out-of-frame code group, `dataEn` is 0 and `dataOut` is 0.
- R8: A /T/ inside a frame that is not followed by /R/ does not end the frame; the next payload code group is passed on.
- R9: On a cycle with `symValid` low, every output keeps its value whatever `sym` carries.
- R10: While `rstN` is low, all outputs are 0, including in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| symValid | input | 1 | Strobe: `sym` holds a new code group |
| sym | input | 5 | Aligned 5-bit code group |
| crs | output | 1 | Carrier sense |
| rxDv | output | 1 | Receive data valid |
| rxEr | output | 1 | Receive error after an idle-terminated frame |
| dataEn | output | 1 | High while `dataOut` carries payload |
| dataOut | output | 5 | Payload code group, zero when `dataEn` is low |

## Verification
The bench targets these corner cases:
- A /J/ followed by data. A design that raised carrier on the lone /J/ would report a false frame.
- A /J/J/K/ run. A design that lost the pending /J/ would miss the frame.
- A single idle inside a frame. A design that ended the frame on one idle would cut off the payload after it.
- A /T/ with no /R/ after it. A design that closed on /T/ alone would drop the rest of the frame.
- The error flag through the gap. A design that cleared it on the /J/ instead of the /K/ would be caught.
- A strobe-less cycle carrying a /J/ and a reset in mid-frame. These expose a design that samples without the strobe or resets only part of its state.

// File: rtl/delim_pkg.sv
package delim_pkg;
  localparam int SYM_W = 5;

  localparam logic [SYM_W-1:0] CODE_J = 5'b11000;
  localparam logic [SYM_W-1:0] CODE_K = 5'b10001;
  localparam logic [SYM_W-1:0] CODE_T = 5'b01101;
  localparam logic [SYM_W-1:0] CODE_R = 5'b00111;
  localparam logic [SYM_W-1:0] CODE_I = 5'b11111;

  typedef enum logic [2:0] {
    CL_DATA, CL_J, CL_K, CL_T, CL_R, CL_I
  } symClass_t;

  // Control to datapath strobes
  typedef struct packed {
    logic pass;   // capture the current code group as payload
    logic clear;  // force payload output to zero
  } dpStrobe_t;
endpackage

// File: rtl/delim_dp.sv
module delim_dp
  import delim_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SYM_W-1:0] sym,
  input  dpStrobe_t        strb,
  output symClass_t        symCls,
  output logic             dataEn,
  output logic [SYM_W-1:0] dataOut
);
  always_comb begin
    unique case (sym)
      CODE_J:  symCls = CL_J;
      CODE_K:  symCls = CL_K;
      CODE_T:  symCls = CL_T;
      CODE_R:  symCls = CL_R;
      CODE_I:  symCls = CL_I;
      default: symCls = CL_DATA;
    endcase
  end

  logic [SYM_W-1:0] outReg;
  logic             enReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
      enReg  <= 1'b0;
    end else if (strb.pass) begin
      outReg <= sym;
      enReg  <= 1'b1;
    end else if (strb.clear) begin
      outReg <= '0;
      enReg  <= 1'b0;
    end
  end

  assign dataEn  = enReg;
  assign dataOut = outReg;

  // R7: output is zero whenever the enable is low
  a_r7_zero_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !dataEn |-> dataOut == '0);
  // R7: enable only rises on a payload capture
  a_r7_rise_on_pass: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataEn) |-> $past(strb.pass));
endmodule

// File: rtl/delim_ctl.sv
module delim_ctl
  import delim_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      symValid,
  input  symClass_t symCls,
  output dpStrobe_t strb,
  output logic      crs,
  output logic      rxDv,
  output logic      rxEr
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_GOTJ, ST_DATA, ST_GOTT, ST_GOTI
  } ctlState_t;

  ctlState_t st, stNext;
  logic crsNext, dvNext, erNext;

  always_comb begin
    stNext     = st;
    crsNext    = crs;
    dvNext     = rxDv;
    erNext     = rxEr;
    strb.pass  = 1'b0;
    strb.clear = 1'b0;
    if (symValid) begin
      strb.clear = 1'b1;
      unique case (st)
        ST_IDLE: if (symCls == CL_J) stNext = ST_GOTJ;
        ST_GOTJ: begin
          if (symCls == CL_K) begin
            stNext  = ST_DATA;
            crsNext = 1'b1;
            dvNext  = 1'b1;
            erNext  = 1'b0;
          end else if (symCls != CL_J) begin
            stNext = ST_IDLE;
          end
        end
        ST_DATA, ST_GOTT, ST_GOTI: begin
          if (st == ST_GOTT && symCls == CL_R) begin
            stNext  = ST_IDLE;
            crsNext = 1'b0;
            dvNext  = 1'b0;
          end else if (st == ST_GOTI && symCls == CL_I) begin
            stNext  = ST_IDLE;
            crsNext = 1'b0;
            dvNext  = 1'b0;
            erNext  = 1'b1;
          end else if (symCls == CL_T) begin
            stNext = ST_GOTT;
          end else if (symCls == CL_I) begin
            stNext = ST_GOTI;
          end else begin
            stNext = ST_DATA;
            if (symCls == CL_DATA) begin
              strb.pass  = 1'b1;
              strb.clear = 1'b0;
            end
          end
        end
        default: stNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st   <= ST_IDLE;
      crs  <= 1'b0;
      rxDv <= 1'b0;
      rxEr <= 1'b0;
    end else begin
      st   <= stNext;
      crs  <= crsNext;
      rxDv <= dvNext;
      rxEr <= erNext;
    end
  end

  // R1: carrier only rises on a strobed /K/
  a_r1_rise_on_k: assert property (@(posedge clk) disable iff (!rstN)
    $rose(crs) |-> ($past(symValid) && $past(symCls) == CL_K));
  // R6: data valid lies within carrier
  a_r6_dv_in_crs: assert property (@(posedge clk) disable iff (!rstN)
    rxDv |-> crs);
  // R6: error flag lies outside carrier
  a_r6_er_out_crs: assert property (@(posedge clk) disable iff (!rstN)
    rxEr |-> !crs);
  // R9: nothing moves without a strobe
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !symValid |=> $stable({crs, rxDv, rxEr}));
  // R5: error flag only clears on a strobed /K/
  a_r5_er_clear_on_k: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxEr) |-> ($past(symValid) && $past(symCls) == CL_K));
endmodule

// File: rtl/delim_carrier_top.sv
module delim_carrier_top
  import delim_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             symValid,
  input  logic [SYM_W-1:0] sym,
  output logic             crs,
  output logic             rxDv,
  output logic             rxEr,
  output logic             dataEn,
  output logic [SYM_W-1:0] dataOut
);
  symClass_t symCls;
  dpStrobe_t strb;

  delim_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .sym     (sym),
    .strb    (strb),
    .symCls  (symCls),
    .dataEn  (dataEn),
    .dataOut (dataOut)
  );

  delim_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .symValid (symValid),
    .symCls   (symCls),
    .strb     (strb),
    .crs      (crs),
    .rxDv     (rxDv),
    .rxEr     (rxEr)
  );
endmodule

// File: tb/sim_delim_carrier_top.sv
module sim_delim_carrier_top;
  localparam time CLK_P = 10ns;
  localparam int  NV    = 31;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic symValid = 1'b0;
  logic [4:0] sym = '0;
  logic crs, rxDv, rxEr, dataEn;
  logic [4:0] dataOut;

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  delim_carrier_top u0 (
    .clk(clk), .rstN(rstN), .symValid(symValid), .sym(sym),
    .crs(crs), .rxDv(rxDv), .rxEr(rxEr), .dataEn(dataEn), .dataOut(dataOut)
  );

  // {valid, sym, crs, rxDv, rxEr, dataEn, dataOut}
  localparam logic [14:0] VEC [NV] = '{
    {1'b1, 5'h1F, 4'b0000, 5'h00},  // idle
    {1'b1, 5'h18, 4'b0000, 5'h00},  // J
    {1'b1, 5'h11, 4'b1100, 5'h00},  // K: R1
    {1'b1, 5'h1E, 4'b1101, 5'h1E},  // data: R7
    {1'b1, 5'h09, 4'b1101, 5'h09},  // data
    {1'b1, 5'h0D, 4'b1100, 5'h00},  // T
    {1'b1, 5'h07, 4'b0000, 5'h00},  // R: R3
    {1'b1, 5'h1F, 4'b0000, 5'h00},
    {1'b1, 5'h18, 4'b0000, 5'h00},  // J
    {1'b1, 5'h09, 4'b0000, 5'h00},  // not K: R2
    {1'b1, 5'h1F, 4'b0000, 5'h00},
    {1'b1, 5'h18, 4'b0000, 5'h00},
    {1'b1, 5'h11, 4'b1100, 5'h00},
    {1'b1, 5'h14, 4'b1101, 5'h14},
    {1'b1, 5'h1F, 4'b1100, 5'h00},  // one idle: R4
    {1'b1, 5'h0A, 4'b1101, 5'h0A},
    {1'b1, 5'h1F, 4'b1100, 5'h00},
    {1'b1, 5'h1F, 4'b0010, 5'h00},  // idle end: R4
    {1'b1, 5'h1F, 4'b0010, 5'h00},  // R5
    {1'b0, 5'h18, 4'b0010, 5'h00},  // no strobe: R9
    {1'b1, 5'h18, 4'b0010, 5'h00},  // J keeps error: R5
    {1'b1, 5'h11, 4'b1100, 5'h00},  // K clears error: R5
    {1'b1, 5'h0D, 4'b1100, 5'h00},  // T
    {1'b1, 5'h0A, 4'b1101, 5'h0A},  // no R: R8
    {1'b1, 5'h0D, 4'b1100, 5'h00},
    {1'b1, 5'h07, 4'b0000, 5'h00},
    {1'b1, 5'h18, 4'b0000, 5'h00},  // J
    {1'b1, 5'h18, 4'b0000, 5'h00},  // J again: R2
    {1'b1, 5'h11, 4'b1100, 5'h00},
    {1'b1, 5'h0D, 4'b1100, 5'h00},
    {1'b1, 5'h07, 4'b0000, 5'h00}
  };

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual crs/dv/er/en/out=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] outs();
    return {crs, rxDv, rxEr, dataEn, dataOut};
  endfunction

  task automatic step(input logic v, input logic [4:0] s);
    symValid = v;
    sym      = s;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      nBad++;
      nChk++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset state", outs(), 9'h000);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][14], VEC[i][13:9]);
      check($sformatf("R1-table vec %0d", i), outs(), VEC[i][8:0]);
    end

    // R10: reset in mid-frame
    step(1'b1, 5'h18);
    step(1'b1, 5'h11);
    step(1'b1, 5'h0B);
    check("R7 payload before reset", outs(), {4'b1101, 5'h0B});
    rstN = 1'b0;
    #1;
    check("R10 mid-frame reset", outs(), 9'h000);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R6: carrier and error exclusive after idle end
    step(1'b1, 5'h18);
    step(1'b1, 5'h11);
    step(1'b1, 5'h1F);
    step(1'b1, 5'h1F);
    check("R6 error outside carrier", {crs, rxEr}, {1'b0, 1'b1} );
    // R9: strobe low with K on the bus does nothing
    step(1'b0, 5'h18);
    step(1'b0, 5'h11);
    check("R9 no strobe keeps gap", outs(), {4'b0010, 5'h00});
    // R2: J then T is not a frame
    step(1'b1, 5'h18);
    step(1'b1, 5'h0D);
    check("R2 J then T", outs(), {4'b0010, 5'h00});

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule